// File: doc/BRIEF.md
# Dual-Issue Integer/Floating-Point Pair Checker

This block sits between instruction fetch and the issue stage of a two-wide in-order pipeline. Every cycle fetch may present a 64-bit packet made of two 32-bit instructions. The upper half is the integer-side slot and the lower half is the floating-point-side slot. The checker decodes both instructions and the up to six register references they carry. It compares those references with a small record of loads issued in the previous cycle, and it then decides whether zero, one or both instructions issue this cycle.

When only the upper instruction can go, the lower one is kept in a one-instruction hold register. In the next cycle it is offered alone as the leading candidate, and fetch is told to keep its packet. A load's result is not readable in the cycle after the load issues. So a load in the upper slot blocks a reader in its own lower slot and a reader in either slot of the next packet. The issue outputs are combinational from the packet and the registered state. The state itself (the hold register and the load record) changes only on the clock edge.

Top module: `dual_issue_pair_chk`

## Requirements
- R1: Packet layout: upper instruction pkt[63:32], lower pkt[31:0]. In each instruction the class is bits [31:28], the destination bits [27:23], source A bits [22:18] and source B bits [17:13]. Class 0 integer op (writes int dst, reads int A and int B). Class 1 integer load (writes int dst, reads int A). Class 2 FP load (writes FP dst, reads int A). Class 3 integer store (reads int A and int B). Class 4 FP store (reads int A and FP B). Classes 5 to 7 are integer-type no-ops. Classes 8 to 14 are FP ops (write FP dst, read FP A and FP B). Class 15 is an FP-type no-op. Classes 0 to 7 are integer-type and 8 to 15 are FP-type.
- R2: With no hold pending, a valid packet with an integer-type upper instruction, an FP-type lower instruction and no hazard issues both: iss_first=1, iss_second=1, fetch_stall=0, lead_is_held=0.
- R3: iss_second is never 1 unless iss_first is 1 in the same cycle.
- R4: An FP load in the upper slot pairs in the same cycle with an FP op in the lower slot that does not read the load's destination.
- R5: If the lower instruction reads the destination of a load in the upper slot of the same packet, only the upper issues, fetch_stall=0, and in the next cycle lead_is_held=1.
- R6: A register written by a load that issued in the previous cycle blocks its readers. If the fresh upper instruction reads it, nothing issues and fetch_stall=1 for that single cycle. If only the lower instruction reads it, the upper issues alone and the lower is held.
- R7: While an instruction is held (lead_is_held=1), fetch_stall=1 and iss_second=0. The held instruction issues on iss_first unless it reads a load from the previous cycle; in that case it waits exactly one cycle.
- R8: An FP-type instruction in the upper slot or an integer-type instruction in the lower slot makes the packet single-issue: the upper issues alone and the lower is held.
- R9: Integer register 0 never creates a dependency. FP register 0 does. Only loads (classes 1 and 2) create dependencies, never integer ops, FP ops or stores.
- R10: With no hold pending and pkt_valid=0, nothing issues and fetch_stall=0.
- R11: While rst is 1 (synchronous, active high) all four outputs are 0. Reset clears the hold and the load record, so a reader right after reset is not blocked by a load issued before reset.
- R12: A load blocks readers for exactly one cycle. An instruction offered two or more cycles after the load issues without waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet is presented on pkt |
| pkt | input | 64 | Two-instruction packet, integer-side slot in the upper half |
| iss_first | output | 1 | Leading candidate (upper instruction or the held one) issues |
| iss_second | output | 1 | Lower instruction issues together with the upper one |
| lead_is_held | output | 1 | The leading candidate this cycle is the held instruction |
| fetch_stall | output | 1 | The presented packet is not consumed and must be presented again |

## Verification
The bench sweeps every pair of instruction classes against a small set of register numbers. Each packet is presented the way fetch would, and every output is compared each cycle against a model built from the requirements.

The directed cases target the following faults:
- A shadow that only checks the upper slot would let a lower-slot reader of last cycle's load issue early.
- A same-packet check that ignores the lower slot would pair a load with its own consumer.
- A hold path that forgets to re-check the load record would issue a held consumer in the shadow cycle.
- Treating integer register 0 as real, or FP register 0 as free, would stall where none is due or miss a stall that is due.
- A reset that keeps the load record would stall the first reader after reset.

// File: rtl/dipc_pkg.sv
package dipc_pkg;
    localparam int INSN_W  = 32;
    localparam int NPOS    = 2;
    localparam int PKT_W   = NPOS * INSN_W;
    localparam int CLS_W   = 4;
    localparam int REG_W   = 5;
    localparam int NSRC    = 2;
    localparam int CLS_LSB = INSN_W - CLS_W;
    localparam int DST_LSB = CLS_LSB - REG_W;
    localparam int SA_LSB  = DST_LSB - REG_W;
    localparam int SB_LSB  = SA_LSB - REG_W;

    localparam logic [CLS_W-1:0] K_INT_OP  = 4'd0;
    localparam logic [CLS_W-1:0] K_INT_LD  = 4'd1;
    localparam logic [CLS_W-1:0] K_FP_LD   = 4'd2;
    localparam logic [CLS_W-1:0] K_INT_ST  = 4'd3;
    localparam logic [CLS_W-1:0] K_FP_ST   = 4'd4;
    localparam logic [CLS_W-1:0] K_FP_NOP  = 4'd15;

    // One architectural register reference; en=0 means "no register".
    typedef struct packed {
        logic             en;
        logic             fp;
        logic [REG_W-1:0] idx;
    } reg_ref_t;

    typedef struct packed {
        logic                      fp_type;
        logic                      is_load;
        reg_ref_t                  dst;
        reg_ref_t [NSRC-1:0]       src;
    } dec_t;

    typedef struct packed {
        logic                      hold_v;
        logic [INSN_W-1:0]         hold_insn;
        reg_ref_t [NPOS-1:0]       shadow;
    } state_t;

    // Integer register 0 is constant, so it never forms a reference.
    function automatic reg_ref_t mk_ref(input logic fp, input logic [REG_W-1:0] idx);
        reg_ref_t r;
        r.en  = fp | (idx != '0);
        r.fp  = fp;
        r.idx = idx;
        return r;
    endfunction

    function automatic reg_ref_t load_ref(input dec_t d);
        return d.is_load ? d.dst : reg_ref_t'('0);
    endfunction
endpackage

// File: rtl/pc_decode.sv
module pc_decode
    import dipc_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [CLS_W-1:0] cls;
    logic [REG_W-1:0] f_dst;
    logic [REG_W-1:0] f_sa;
    logic [REG_W-1:0] f_sb;
    logic             unused_low;

    assign cls        = insn[CLS_LSB +: CLS_W];
    assign f_dst      = insn[DST_LSB +: REG_W];
    assign f_sa       = insn[SA_LSB  +: REG_W];
    assign f_sb       = insn[SB_LSB  +: REG_W];
    assign unused_low = ^insn[SB_LSB-1:0];

    always_comb begin
        dec         = '0;
        dec.fp_type = cls[CLS_W-1];
        case (cls)
            K_INT_OP: begin
                dec.dst    = mk_ref(1'b0, f_dst);
                dec.src[0] = mk_ref(1'b0, f_sa);
                dec.src[1] = mk_ref(1'b0, f_sb);
            end
            K_INT_LD: begin
                dec.is_load = 1'b1;
                dec.dst     = mk_ref(1'b0, f_dst);
                dec.src[0]  = mk_ref(1'b0, f_sa);
            end
            K_FP_LD: begin
                dec.is_load = 1'b1;
                dec.dst     = mk_ref(1'b1, f_dst);
                dec.src[0]  = mk_ref(1'b0, f_sa);
            end
            K_INT_ST: begin
                dec.src[0] = mk_ref(1'b0, f_sa);
                dec.src[1] = mk_ref(1'b0, f_sb);
            end
            K_FP_ST: begin
                dec.src[0] = mk_ref(1'b0, f_sa);
                dec.src[1] = mk_ref(1'b1, f_sb);
            end
            K_FP_NOP: begin
                dec.dst = '0;
            end
            default: begin
                if (cls[CLS_W-1]) begin
                    dec.dst    = mk_ref(1'b1, f_dst);
                    dec.src[0] = mk_ref(1'b1, f_sa);
                    dec.src[1] = mk_ref(1'b1, f_sb);
                end
            end
        endcase
    end
endmodule

// File: rtl/pc_hazard.sv
module pc_hazard
    import dipc_pkg::*;
#(
    parameter int NENT = 2
) (
    input  dec_t                dec,
    input  reg_ref_t [NENT-1:0] ents,
    output logic                hit
);
    logic [NSRC*NENT-1:0] match;
    logic                 unused_fields;

    assign unused_fields = ^{dec.fp_type, dec.is_load, dec.dst};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar e = 0; e < NENT; e++) begin : g_ent
            assign match[s*NENT + e] = dec.src[s].en && ents[e].en &&
                                       (dec.src[s].fp  == ents[e].fp) &&
                                       (dec.src[s].idx == ents[e].idx);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk
    import dipc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_valid,
    input  logic [PKT_W-1:0] pkt,
    output logic             iss_first,
    output logic             iss_second,
    output logic             lead_is_held,
    output logic             fetch_stall
);
    localparam int NCAND  = 3;
    localparam int C_UP   = 0;
    localparam int C_LO   = 1;
    localparam int C_HOLD = 2;

    state_t              st_q, st_d;
    logic [INSN_W-1:0]   cand     [NCAND];
    dec_t                cand_dec [NCAND];
    logic [NCAND-1:0]    sh_hit;
    logic                intra_hit;
    reg_ref_t [0:0]      up_load;
    dec_t                pos_dec  [NPOS];
    logic [NPOS-1:0]     pos_go;
    logic                slot_ok;
    logic                unused_bits;

    assign cand[C_UP]   = pkt[PKT_W-1 -: INSN_W];
    assign cand[C_LO]   = pkt[INSN_W-1:0];
    assign cand[C_HOLD] = st_q.hold_insn;

    for (genvar g = 0; g < NCAND; g++) begin : g_cand
        pc_decode u_dec (
            .insn (cand[g]),
            .dec  (cand_dec[g])
        );
        pc_hazard #(.NENT(NPOS)) u_shadow (
            .dec  (cand_dec[g]),
            .ents (st_q.shadow),
            .hit  (sh_hit[g])
        );
    end

    // Lower slot against a load in the upper slot of the same packet.
    assign up_load[0] = load_ref(cand_dec[C_UP]);
    pc_hazard #(.NENT(1)) u_intra (
        .dec  (cand_dec[C_LO]),
        .ents (up_load),
        .hit  (intra_hit)
    );

    assign unused_bits = ^{cand_dec[C_UP], cand_dec[C_LO], cand_dec[C_HOLD]};
    assign slot_ok     = !cand_dec[C_UP].fp_type && cand_dec[C_LO].fp_type;

    // Issue position 0 is the held instruction when one is pending.
    assign pos_dec[0] = st_q.hold_v ? cand_dec[C_HOLD] : cand_dec[C_UP];
    assign pos_dec[1] = cand_dec[C_LO];
    assign pos_go     = {iss_second, iss_first};

    always_comb begin
        st_d         = st_q;
        iss_first    = 1'b0;
        iss_second   = 1'b0;
        lead_is_held = 1'b0;
        fetch_stall  = 1'b0;

        if (st_q.hold_v) begin
            lead_is_held = 1'b1;
            fetch_stall  = 1'b1;
            iss_first    = !sh_hit[C_HOLD];
            if (iss_first) begin
                st_d.hold_v = 1'b0;
            end
        end else if (pkt_valid) begin
            iss_first   = !sh_hit[C_UP];
            iss_second  = iss_first && slot_ok && !sh_hit[C_LO] && !intra_hit;
            fetch_stall = !iss_first;
            if (iss_first && !iss_second) begin
                st_d.hold_v    = 1'b1;
                st_d.hold_insn = cand[C_LO];
            end
        end

        for (int p = 0; p < NPOS; p++) begin
            st_d.shadow[p] = pos_go[p] ? load_ref(pos_dec[p]) : reg_ref_t'('0);
        end

        if (rst) begin
            st_d         = '0;
            iss_first    = 1'b0;
            iss_second   = 1'b0;
            lead_is_held = 1'b0;
            fetch_stall  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/dipc_checker.sv
module dipc_checker (
    input logic clk,
    input logic rst,
    input logic pkt_valid,
    input logic iss_first,
    input logic iss_second,
    input logic lead_is_held,
    input logic fetch_stall
);
    p_second_needs_first_r3: assert property (@(posedge clk) disable iff (rst)
        iss_second |-> iss_first);

    p_split_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (iss_first && !iss_second && !lead_is_held) |=> lead_is_held);

    p_fresh_stall_once_r6: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !lead_is_held && !iss_first) |=> (iss_first || !pkt_valid));

    p_held_alone_r7: assert property (@(posedge clk) disable iff (rst)
        lead_is_held |-> (!iss_second && fetch_stall));

    p_held_wait_once_r12: assert property (@(posedge clk) disable iff (rst)
        (lead_is_held && !iss_first) |=> (lead_is_held && iss_first));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!pkt_valid && !lead_is_held) |-> (!iss_first && !fetch_stall));

    p_reset_clears_hold_r11: assert property (@(posedge clk)
        rst |=> !lead_is_held);
endmodule

bind dual_issue_pair_chk dipc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .pkt_valid    (pkt_valid),
    .iss_first    (iss_first),
    .iss_second   (iss_second),
    .lead_is_held (lead_is_held),
    .fetch_stall  (fetch_stall)
);

// File: tb/sim_dual_issue_pair_chk.sv
`timescale 1ns/1ps
module sim_dual_issue_pair_chk;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [63:0] pkt = '0;
    logic        iss_first, iss_second, lead_is_held, fetch_stall;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dual_issue_pair_chk u0 (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt(pkt),
        .iss_first(iss_first), .iss_second(iss_second),
        .lead_is_held(lead_is_held), .fetch_stall(fetch_stall)
    );

    // Reference model state, derived from the requirements.
    bit          m_hv;
    logic [31:0] m_h;
    bit          m_sv [2];
    bit          m_sf [2];
    logic [4:0]  m_si [2];
    bit          last_consumed;
    logic        o0, o1, oh, os;

    function automatic logic [31:0] ins(input int c, input int d, input int a, input int b);
        logic [3:0] cc = c[3:0];
        logic [4:0] dd = d[4:0];
        logic [4:0] aa = a[4:0];
        logic [4:0] bb = b[4:0];
        return {cc, dd, aa, bb, 13'd0};
    endfunction

    // R1 and R9: does insn read register (fp, idx)?
    function automatic bit reads(input logic [31:0] x, input bit fp, input logic [4:0] idx);
        logic [3:0] c = x[31:28];
        logic [4:0] a = x[22:18];
        logic [4:0] b = x[17:13];
        if (!fp && idx == 0) return 0;
        case (c)
            4'd0, 4'd3: return !fp && (a == idx || b == idx);
            4'd1, 4'd2: return !fp && a == idx;
            4'd4:       return (!fp && a == idx) || (fp && b == idx);
            4'd5, 4'd6, 4'd7, 4'd15: return 0;
            default:    return fp && (a == idx || b == idx);
        endcase
    endfunction

    function automatic bit ld_dst(input logic [31:0] x, output bit fp, output logic [4:0] idx);
        idx = x[27:23];
        fp  = (x[31:28] == 4'd2);
        if (x[31:28] == 4'd1) return idx != 0;
        return x[31:28] == 4'd2;
    endfunction

    function automatic bit haz(input logic [31:0] x);
        bit h = 0;
        for (int e = 0; e < 2; e++) if (m_sv[e] && reads(x, m_sf[e], m_si[e])) h = 1;
        return h;
    endfunction

    function automatic bit intra(input logic [31:0] l, input logic [31:0] r);
        bit fp; logic [4:0] idx;
        if (!ld_dst(l, fp, idx)) return 0;
        return reads(r, fp, idx);
    endfunction

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, nm, act, exp);
        end
    endtask

    task automatic run_cycle(input logic [63:0] p, input logic v, input string tag);
        logic [31:0] L, R;
        logic e0, e1, eh, es;
        bit hb, fp;
        logic [4:0] idx;
        pkt = p; pkt_valid = v;
        @(negedge clk);
        L = p[63:32]; R = p[31:0];
        e0 = 0; e1 = 0; eh = 0; es = 0;
        hb = m_hv;
        if (rst) begin
            e0 = 0;
        end else if (m_hv) begin
            eh = 1; es = 1; e0 = !haz(m_h);
        end else if (v) begin
            e0 = !haz(L);
            e1 = e0 && !L[31] && R[31] && !haz(R) && !intra(L, R);
            es = !e0;
        end
        o0 = iss_first; o1 = iss_second; oh = lead_is_held; os = fetch_stall;
        chk(tag, "iss_first", o0, e0);
        chk(tag, "iss_second", o1, e1);
        chk(tag, "lead_is_held", oh, eh);
        chk(tag, "fetch_stall", os, es);
        chk("R3", "second_implies_first", o1 && !o0, 1'b0);
        // advance model
        for (int e = 0; e < 2; e++) m_sv[e] = 0;
        if (hb) begin
            if (e0) begin
                m_sv[0] = ld_dst(m_h, fp, idx); m_sf[0] = fp; m_si[0] = idx;
                m_hv = 0;
            end
        end else if (v) begin
            if (e0) begin m_sv[0] = ld_dst(L, fp, idx); m_sf[0] = fp; m_si[0] = idx; end
            if (e1) begin m_sv[1] = ld_dst(R, fp, idx); m_sf[1] = fp; m_si[1] = idx; end
            if (e0 && !e1) begin m_hv = 1; m_h = R; end
        end
        last_consumed = !hb && v && !es && !rst;
        if (rst) begin
            m_hv = 0;
            for (int e = 0; e < 2; e++) m_sv[e] = 0;
        end
        @(posedge clk); #1;
    endtask

    task automatic issue_pkt(input logic [63:0] p, input string tag);
        int n = 0;
        last_consumed = 0;
        while (!last_consumed && n < 6) begin
            run_cycle(p, 1'b1, tag);
            n++;
        end
        if (!last_consumed) begin
            checks++; failures++;
            $display("FAIL %s packet never consumed: actual=0 expected=1", tag);
        end
    endtask

    task automatic hand(input string tag, input logic e0, input logic e1, input logic eh, input logic es);
        chk(tag, "hand iss_first", o0, e0);
        chk(tag, "hand iss_second", o1, e1);
        chk(tag, "hand lead_is_held", oh, eh);
        chk(tag, "hand fetch_stall", os, es);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] ind;
        m_hv = 0; m_h = '0;
        for (int e = 0; e < 2; e++) begin m_sv[e] = 0; m_sf[e] = 0; m_si[e] = '0; end
        ind = {ins(0, 20, 21, 22), ins(8, 23, 24, 25)};
        @(posedge clk); #1;
        // R11: outputs quiet during reset
        rst = 1;
        for (int i = 0; i < 3; i++) begin
            run_cycle(ind, 1'b1, "R11 reset");
            hand("R11 reset", 0, 0, 0, 0);
        end
        rst = 0;

        // R2: plain pair
        run_cycle({ins(0, 1, 2, 3), ins(8, 1, 2, 3)}, 1'b1, "R2 pair");
        hand("R2 pair", 1, 1, 0, 0);

        // R4: FP load pairs with independent FP op
        run_cycle({ins(2, 4, 5, 0), ins(9, 6, 7, 8)}, 1'b1, "R4 fpld pair");
        hand("R4 fpld pair", 1, 1, 0, 0);
        // R6: lower reads last cycle's load -> upper alone, lower held
        run_cycle({ins(0, 1, 2, 3), ins(8, 9, 4, 2)}, 1'b1, "R6 lower shadow");
        hand("R6 lower shadow", 1, 0, 0, 0);
        run_cycle(ind, 1'b1, "R7 held issues");
        hand("R7 held issues", 1, 0, 1, 1);
        issue_pkt(ind, "R7 refetch");

        // R5: same-packet load-use, held consumer waits one shadow cycle
        run_cycle({ins(2, 10, 1, 0), ins(8, 11, 10, 3)}, 1'b1, "R5 intra");
        hand("R5 intra", 1, 0, 0, 0);
        run_cycle(ind, 1'b1, "R7 held in shadow");
        hand("R7 held in shadow", 0, 0, 1, 1);
        run_cycle(ind, 1'b1, "R12 held after shadow");
        hand("R12 held after shadow", 1, 0, 1, 1);
        issue_pkt(ind, "R5 refetch");

        // R6: upper reads last cycle's load -> one stall cycle
        run_cycle({ins(1, 7, 1, 0), ins(8, 12, 13, 14)}, 1'b1, "R6 int load");
        hand("R6 int load", 1, 1, 0, 0);
        run_cycle({ins(0, 8, 7, 2), ins(8, 12, 13, 14)}, 1'b1, "R6 upper shadow");
        hand("R6 upper shadow", 0, 0, 0, 1);
        run_cycle({ins(0, 8, 7, 2), ins(8, 12, 13, 14)}, 1'b1, "R6 retry");
        hand("R6 retry", 1, 1, 0, 0);

        // R12: reader two cycles after the load is free
        run_cycle({ins(2, 12, 1, 0), ins(8, 15, 16, 17)}, 1'b1, "R12 load");
        run_cycle(ind, 1'b1, "R12 gap");
        run_cycle({ins(4, 0, 1, 12), ins(8, 18, 12, 12)}, 1'b1, "R12 late reader");
        hand("R12 late reader", 1, 1, 0, 0);

        // R8: slot type mismatch
        run_cycle({ins(8, 1, 2, 3), ins(8, 4, 5, 6)}, 1'b1, "R8 fp in upper");
        hand("R8 fp in upper", 1, 0, 0, 0);
        run_cycle(ind, 1'b1, "R8 held");
        hand("R8 held", 1, 0, 1, 1);
        issue_pkt({ins(0, 1, 2, 3), ins(0, 4, 5, 6)}, "R8 int in lower");
        hand("R8 int in lower", 1, 0, 0, 0);
        run_cycle(ind, 1'b1, "R8 held int");
        hand("R8 held int", 1, 0, 1, 1);
        issue_pkt(ind, "R8 refetch");

        // R9: int r0 never a dependency, FP f0 is, stores/ops never create one
        run_cycle({ins(1, 0, 1, 0), ins(15, 0, 0, 0)}, 1'b1, "R9 load r0");
        run_cycle({ins(0, 2, 0, 0), ins(8, 3, 4, 5)}, 1'b1, "R9 read r0");
        hand("R9 read r0", 1, 1, 0, 0);
        run_cycle({ins(2, 0, 1, 0), ins(15, 0, 0, 0)}, 1'b1, "R9 load f0");
        run_cycle({ins(0, 2, 3, 4), ins(8, 5, 0, 6)}, 1'b1, "R9 read f0");
        hand("R9 read f0", 1, 0, 0, 0);
        run_cycle(ind, 1'b1, "R9 held f0");
        issue_pkt(ind, "R9 refetch");
        run_cycle({ins(0, 9, 1, 2), ins(8, 9, 3, 4)}, 1'b1, "R9 op writes");
        run_cycle({ins(3, 0, 9, 9), ins(8, 5, 9, 9)}, 1'b1, "R9 no op dep");
        hand("R9 no op dep", 1, 1, 0, 0);

        // R10: idle packet separates load from reader
        run_cycle({ins(1, 11, 1, 0), ins(15, 0, 0, 0)}, 1'b1, "R10 load");
        run_cycle(ind, 1'b0, "R10 idle");
        hand("R10 idle", 0, 0, 0, 0);
        run_cycle({ins(0, 2, 11, 11), ins(8, 1, 2, 3)}, 1'b1, "R10 after idle");
        hand("R10 after idle", 1, 1, 0, 0);

        // R11: reset wipes the load record and the hold
        run_cycle({ins(1, 13, 1, 0), ins(0, 1, 2, 3)}, 1'b1, "R11 pre");
        rst = 1;
        run_cycle(ind, 1'b1, "R11 mid reset");
        hand("R11 mid reset", 0, 0, 0, 0);
        rst = 0;
        run_cycle({ins(0, 2, 13, 13), ins(8, 1, 2, 3)}, 1'b1, "R11 after reset");
        hand("R11 after reset", 1, 1, 0, 0);

        // R1: sweep of all class pairs over a small register set
        for (int lc = 0; lc < 16; lc++) begin
            for (int rc = 0; rc < 16; rc++) begin
                for (int p = 0; p < 27; p++) begin
                    issue_pkt({ins(lc, p % 3, (p + 1) % 3, (p + 2) % 3),
                               ins(rc, (p / 3 + 1) % 3, (p / 3) % 3, (p / 9) % 3)},
                              "R1 sweep");
                end
            end
        end
        run_cycle(ind, 1'b0, "R10 drain");
        run_cycle(ind, 1'b0, "R10 drain");
        hand("R10 drain", 0, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule